// File: doc/BRIEF.md
# Configuration Image Checksum Transfer Engine

This block moves a whole device configuration image between a word-addressed non-volatile memory controller and a local word buffer. Toward the controller it drives a command word strobe, a data word strobe and reads back a data word and a completion flag. Toward the host it takes a one-cycle start request that selects between pulling the image into the buffer and pushing the buffer out to the memory.

A pull walks every word address, stores each returned word in the buffer at the same index, and accumulates a 16-bit checksum over the configuration region only. A push opens the memory for writing, programs every word, replaces the buffer's checksum word with a freshly computed sum, and closes the memory for writing again. After every command the engine polls the completion flag at a fixed spacing and gives up after a bounded number of polls, reporting a timeout.

The checksum slot sits directly after the configuration region; the control region after it is moved but never summed. Region bounds, poll spacing, poll count and the command opcodes are parameters.

Top module: `eepcs_engine`

## Requirements
- R1: While and after reset, busy, done, timeout, cmd_valid, data_wr and buf_we are low and checksum is 0.
- R2: A pull issues, for each address in ascending order, a command equal to 16'h8000 ORed with the address in bits 5:0, and stores data_in into buffer index equal to that address once completion is seen; a pull of the default image issues exactly 64 commands and leaves the buffer equal to the memory.
- R3: After a pull, checksum equals the 16-bit sum of the words at addresses 0 through 20.
- R4: The checksum slot (address 21) and the control region (addresses 22 to 63) are transferred but never added into the checksum.
- R5: A push starts with the write-open command 16'h3000 and ends with the write-close command 16'h1000, each waited for, for 66 commands in total.
- R6: For every word programmed, data_wr loads data_out in the cycle just before the write command 16'h4000 ORed with the address.
- R7: During a push, the slot at address 21 receives the checksum of the buffer words 0 through 20; the buffer's own word 21 is ignored, and every other word is copied unchanged; checksum reports that sum.
- R8: The first completion poll happens in the cycle after the command, then every POLL_GAP+1 cycles, for POLL_MAX polls; completion seen at the last poll still counts as success.
- R9: If POLL_MAX polls all see completion low, the operation stops with no further command, done pulses with timeout high, and a timed-out command issued one cycle after start yields done at cycle 3+(POLL_MAX-1)*(POLL_GAP+1) after start.
- R10: busy is high from the cycle after an accepted start until done; done is a one-cycle pulse after which busy is low, and checksum and timeout then hold until the next start.
- R11: Checksum addition wraps modulo 2^16 (21 words of 16'hFFFF give 16'hFFEB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation (accepted when idle) |
| start_write | input | 1 | Operation select with start: 1 push, 0 pull |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last operation ended on a poll timeout |
| checksum | output | 16 | Configuration-region checksum of the last operation |
| cmd_valid | output | 1 | Command word strobe to the memory controller |
| cmd_word | output | 16 | Opcode ORed with word address |
| data_wr | output | 1 | Data register load strobe |
| data_out | output | 16 | Word loaded into the data register |
| data_in | input | 16 | Data register read-back |
| ctl_done | input | 1 | Controller completion flag |
| buf_addr | output | ADDR_W | Local buffer word index |
| buf_we | output | 1 | Local buffer write enable |
| buf_wdata | output | 16 | Word written to the buffer |
| buf_rdata | input | 16 | Buffer word at buf_addr, combinational |

## Verification
The properties assume the controller drops its completion flag on the edge that accepts a command and keeps data_in valid from then until the next command, so a poll never sees a stale completion, and that the buffer returns its word combinationally. They also assume start is only raised while idle. The bench's controller model clears the flag on every command and raises it after a programmed latency, loads data_in at command time, and the bench only pulses start after observing done.

// File: rtl/eepcs_pkg.sv
package eepcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CMD,
        ST_POLL,
        ST_FIN
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_OPEN,
        PH_MOVE,
        PH_CLOSE
    } eng_phase_t;

    typedef struct packed {
        eng_state_t st;
        eng_phase_t ph;
        logic       wr;
        logic       tmo;
    } eng_ctx_t;

    function automatic logic in_span(int a, int lo, int hi);
        return (a >= lo) && (a < hi);
    endfunction

    function automatic logic [15:0] cmd_join(logic [15:0] op, logic [15:0] a);
        return op | a;
    endfunction

endpackage

// File: rtl/eepcs_poll.sv
module eepcs_poll #(
    parameter int POLL_GAP = 100000,
    parameter int POLL_MAX = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic ctl_done,
    output logic ok,
    output logic tmo
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int TRY_W = $clog2(POLL_MAX + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

    logic             active_q;
    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;
    logic             check;

    assign check = active_q && (gap_q == '0);
    assign ok    = check && ctl_done;
    assign tmo   = check && !ctl_done && (try_q == TRY_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            gap_q    <= '0;
            try_q    <= '0;
        end else if (arm) begin
            active_q <= 1'b1;
            gap_q    <= '0;
            try_q    <= '0;
        end else if (active_q) begin
            if (ok || tmo) begin
                active_q <= 1'b0;
            end else if (check) begin
                try_q <= try_q + 1'b1;
                gap_q <= GAP_LOAD;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/eepcs_sum.sv
module eepcs_sum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum
);
    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_q + add_val;
        end
    end

    assign sum = acc_q;
endmodule

// File: rtl/eepcs_engine.sv
module eepcs_engine
    import eepcs_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          CFG_BEGIN = 0,
    parameter int          CFG_END   = 21,
    parameter int          CTL_BEGIN = 22,
    parameter int          MAX_ADDR  = 64,
    parameter int          POLL_GAP  = 100000,
    parameter int          POLL_MAX  = 10,
    parameter logic [15:0] CMD_READ  = 16'h8000,
    parameter logic [15:0] CMD_WRITE = 16'h4000,
    parameter logic [15:0] CMD_WEN   = 16'h3000,
    parameter logic [15:0] CMD_WDIS  = 16'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [15:0]       checksum,
    output logic              cmd_valid,
    output logic [15:0]       cmd_word,
    output logic              data_wr,
    output logic [15:0]       data_out,
    input  logic [15:0]       data_in,
    input  logic              ctl_done,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_we,
    output logic [15:0]       buf_wdata,
    input  logic [15:0]       buf_rdata
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(CFG_BEGIN);
    localparam logic [ADDR_W-1:0] A_SLOT  = ADDR_W'(CFG_END);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(CTL_BEGIN);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(MAX_ADDR - 1);

    eng_ctx_t          ctx_q, ctx_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [15:0]       addr_ext;
    logic              in_cfg, at_slot, at_last;
    logic              poll_ok, poll_tmo;
    logic              sum_clr, sum_add;
    logic [15:0]       sum_val, sum_q;
    logic              moving, reading;

    assign addr_ext = 16'(addr_q);
    assign in_cfg   = in_span(int'(addr_q), CFG_BEGIN, CFG_END);
    assign at_slot  = (addr_q == A_SLOT);
    assign at_last  = (addr_q == A_LAST);
    assign moving   = (ctx_q.ph == PH_MOVE);
    assign reading  = !ctx_q.wr;

    // sequencing of commands, loads and polls
    always_comb begin
        ctx_d  = ctx_q;
        addr_d = addr_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.wr  = start_write;
                    ctx_d.tmo = 1'b0;
                    ctx_d.ph  = start_write ? PH_OPEN : PH_MOVE;
                    ctx_d.st  = ST_CMD;
                    addr_d    = A_FIRST;
                end
            end
            ST_LOAD: ctx_d.st = ST_CMD;
            ST_CMD:  ctx_d.st = ST_POLL;
            ST_POLL: begin
                if (poll_tmo) begin
                    ctx_d.tmo = 1'b1;
                    ctx_d.st  = ST_FIN;
                end else if (poll_ok) begin
                    case (ctx_q.ph)
                        PH_OPEN: begin
                            ctx_d.ph = PH_MOVE;
                            ctx_d.st = ST_LOAD;
                        end
                        PH_MOVE: begin
                            if (at_last) begin
                                if (ctx_q.wr) begin
                                    ctx_d.ph = PH_CLOSE;
                                    ctx_d.st = ST_CMD;
                                end else begin
                                    ctx_d.st = ST_FIN;
                                end
                            end else begin
                                addr_d   = at_slot ? A_CTL : addr_q + 1'b1;
                                ctx_d.st = ctx_q.wr ? ST_LOAD : ST_CMD;
                            end
                        end
                        default: ctx_d.st = ST_FIN;
                    endcase
                end
            end
            ST_FIN:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{st: ST_IDLE, ph: PH_MOVE, wr: 1'b0, tmo: 1'b0};
            addr_q <= '0;
        end else begin
            ctx_q  <= ctx_d;
            addr_q <= addr_d;
        end
    end

    // command word selection
    always_comb begin
        cmd_word = '0;
        if (ctx_q.st == ST_CMD) begin
            case (ctx_q.ph)
                PH_OPEN:  cmd_word = CMD_WEN;
                PH_CLOSE: cmd_word = CMD_WDIS;
                default:  cmd_word = cmd_join(ctx_q.wr ? CMD_WRITE : CMD_READ, addr_ext);
            endcase
        end
    end

    assign cmd_valid = (ctx_q.st == ST_CMD);
    assign data_wr   = (ctx_q.st == ST_LOAD);
    assign data_out  = data_wr ? (at_slot ? sum_q : buf_rdata) : 16'h0000;

    assign buf_addr  = addr_q;
    assign buf_we    = (ctx_q.st == ST_POLL) && poll_ok && moving && reading;
    assign buf_wdata = data_in;

    // push sums at load time, pull sums at completion
    assign sum_clr = (ctx_q.st == ST_IDLE) && start;
    assign sum_add = in_cfg && (((ctx_q.st == ST_LOAD) && ctx_q.wr) || buf_we);
    assign sum_val = ctx_q.wr ? buf_rdata : data_in;

    eepcs_poll #(
        .POLL_GAP (POLL_GAP),
        .POLL_MAX (POLL_MAX)
    ) u_poll (
        .clk      (clk),
        .rst      (rst),
        .arm      (cmd_valid),
        .ctl_done (ctl_done),
        .ok       (poll_ok),
        .tmo      (poll_tmo)
    );

    eepcs_sum #(
        .W (16)
    ) u_sum (
        .clk     (clk),
        .rst     (rst),
        .clr     (sum_clr),
        .add_en  (sum_add),
        .add_val (sum_val),
        .sum     (sum_q)
    );

    assign busy     = (ctx_q.st != ST_IDLE);
    assign done     = (ctx_q.st == ST_FIN);
    assign timeout  = ctx_q.tmo;
    assign checksum = sum_q;
endmodule

// File: rtl/eepcs_engine_chk.sv
module eepcs_engine_chk #(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] CMD_WRITE = 16'h4000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        timeout,
    input logic [15:0] checksum,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        data_wr,
    input logic        buf_we,
    input logic        ctl_done
);
    // R6: a data load is followed at once by a write command
    a_r6_load_then_write: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (cmd_valid && (cmd_word[15:ADDR_W] == CMD_WRITE[15:ADDR_W])));

    // R8: each command is followed by at least one poll cycle
    a_r8_cmd_spacing: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R2: a word is stored only once the controller reports completion
    a_r2_store_on_done: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> ctl_done);

    // R9: timeout appears together with the completion pulse
    a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> done);

    // R10: done is a single pulse that ends the operation
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R10: commands only while busy
    a_r10_cmd_in_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

    // R10: results hold while idle
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(checksum) && $stable(timeout)));
endmodule

bind eepcs_engine eepcs_engine_chk #(
    .ADDR_W    (ADDR_W),
    .CMD_WRITE (CMD_WRITE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .checksum  (checksum),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .data_wr   (data_wr),
    .buf_we    (buf_we),
    .ctl_done  (ctl_done)
);

// File: tb/eepcs_engine_bench.sv
module eepcs_engine_bench;
    localparam int PGAP  = 3;
    localparam int PMAX  = 4;
    localparam int NW    = 64;
    localparam int SLOT  = 21;
    localparam int TO_CYC = 3 + (PMAX - 1) * (PGAP + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_write = 1'b0;
    logic        busy, done, timeout;
    logic [15:0] checksum;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        data_wr;
    logic [15:0] data_out;
    logic [15:0] data_in;
    logic        ctl_done;
    logic [5:0]  buf_addr;
    logic        buf_we;
    logic [15:0] buf_wdata;
    logic [15:0] buf_rdata;

    always #2 clk = ~clk;

    eepcs_engine #(
        .POLL_GAP (PGAP),
        .POLL_MAX (PMAX)
    ) u_eepcs_engine (
        .clk (clk), .rst (rst), .start (start), .start_write (start_write),
        .busy (busy), .done (done), .timeout (timeout), .checksum (checksum),
        .cmd_valid (cmd_valid), .cmd_word (cmd_word), .data_wr (data_wr),
        .data_out (data_out), .data_in (data_in), .ctl_done (ctl_done),
        .buf_addr (buf_addr), .buf_we (buf_we), .buf_wdata (buf_wdata),
        .buf_rdata (buf_rdata)
    );

    function automatic logic [15:0] pat(input logic [15:0] seed, input int i);
        if (seed == 16'h0000) return 16'hFFFF;
        return 16'(seed * 16'h9E37) ^ 16'(i * 291 + (i << 8));
    endfunction

    // memory controller and buffer model
    logic [15:0] eem  [NW];
    logic [15:0] bufm [NW];
    logic [15:0] data_reg;
    logic [15:0] first_cmd, last_cmd;
    logic        loaded, wen;
    int          ncmd, viol, cnt;
    int          lat = 2;
    logic        fill_en = 1'b0;
    logic [15:0] fill_se = 16'h0001, fill_sb = 16'h0002;

    assign buf_rdata = bufm[buf_addr];

    always @(posedge clk) begin
        if (rst) begin
            ctl_done <= 1'b0; cnt <= 0; wen <= 1'b0; loaded <= 1'b0;
            ncmd <= 0; viol <= 0; data_in <= '0; data_reg <= '0;
            first_cmd <= '0; last_cmd <= '0;
        end else if (fill_en) begin
            for (int i = 0; i < NW; i++) begin
                eem[i]  <= pat(fill_se, i);
                bufm[i] <= pat(fill_sb, i);
            end
            ncmd <= 0; viol <= 0; loaded <= 1'b0; wen <= 1'b0;
        end else begin
            if (buf_we) bufm[buf_addr] <= buf_wdata;
            if (data_wr) begin
                data_reg <= data_out;
                loaded   <= 1'b1;
            end
            if (cmd_valid) begin
                ncmd <= ncmd + 1;
                if (ncmd == 0) first_cmd <= cmd_word;
                last_cmd <= cmd_word;
                if (lat == 0) ctl_done <= 1'b1;
                else begin
                    ctl_done <= 1'b0;
                    cnt      <= lat;
                end
                case (cmd_word[15:12])
                    4'h8: data_in <= eem[cmd_word[5:0]];
                    4'h4: begin
                        if (!wen || !loaded) viol <= viol + 1;
                        else eem[cmd_word[5:0]] <= data_reg;
                        loaded <= 1'b0;
                    end
                    4'h3: wen <= 1'b1;
                    4'h1: wen <= 1'b0;
                    default: viol <= viol + 1;
                endcase
            end else if (cnt > 1) begin
                cnt <= cnt - 1;
            end else if (cnt == 1) begin
                ctl_done <= 1'b1;
                cnt      <= 0;
            end
        end
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [15:0] se, input logic [15:0] sb);
        @(negedge clk);
        fill_se = se; fill_sb = sb; fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic run_op(input logic wr, output int cyc, output logic t_o,
                          output logic [15:0] cs, output bit busy_ok);
        bit fin;
        fin = 0; cyc = 0; busy_ok = 1; t_o = 1'b0; cs = '0;
        @(negedge clk);
        start = 1'b1; start_write = wr;
        while (!fin && cyc < 20000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) begin
                fin = 1; t_o = timeout; cs = checksum;
            end else if (!busy) busy_ok = 0;
        end
        if (!fin) chk(0, "R10 watchdog expired", cyc, 0);
        @(negedge clk);
        chk(!busy && !done && checksum == cs && timeout == t_o, "R10 idle after done",
            {busy, done}, 0);
    endtask

    function automatic logic [15:0] cfg_sum(input logic [15:0] seed);
        logic [15:0] s = '0;
        for (int i = 0; i < SLOT; i++) s = s + pat(seed, i);
        return s;
    endfunction

    // {push, latency, seed}
    localparam logic [23:0] VEC [6] = '{
        {1'b0, 7'd0,  16'h1234},
        {1'b0, 7'd12, 16'h00A5},
        {1'b1, 7'd2,  16'h5A5A},
        {1'b1, 7'd12, 16'hC001},
        {1'b0, 7'd3,  16'h0000},
        {1'b1, 7'd1,  16'h0000}
    };

    initial begin
        int          cyc;
        logic        t_o;
        logic [15:0] cs, es;
        bit          bok, same;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !timeout && checksum == 0 && !cmd_valid && !data_wr && !buf_we,
            "R1 state in reset", {busy, done, timeout}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !timeout && checksum == 0 && !cmd_valid && !data_wr && !buf_we,
            "R1 state after reset", checksum, 0);

        for (int v = 0; v < 6; v++) begin
            logic        wr;
            logic [15:0] sd;
            wr  = VEC[v][23];
            lat = int'(VEC[v][22:16]);
            sd  = VEC[v][15:0];
            if (wr) do_fill(sd ^ 16'h7777, sd);
            else    do_fill(sd, sd ^ 16'h3C3C);
            run_op(wr, cyc, t_o, cs, bok);
            chk(bok, "R10 busy through operation", v, 0);
            chk(t_o == 1'b0, "R8 no timeout at in-limit latency", t_o, 0);
            es = cfg_sum(sd);
            if (sd == 16'h0000)
                chk(cs == 16'hFFEB && es == 16'hFFEB, "R11 wraparound checksum", cs, 16'hFFEB);
            chk(cs == es, wr ? "R7 push checksum" : "R3 pull checksum", cs, es);
            same = 1;
            if (wr) begin
                for (int i = 0; i < NW; i++)
                    if (i == SLOT) begin if (eem[i] != es) same = 0; end
                    else if (eem[i] != bufm[i]) same = 0;
                chk(same, "R7 memory image with regenerated slot", eem[SLOT], es);
                chk(ncmd == 66, "R5 push command count", ncmd, 66);
                chk(first_cmd == 16'h3000 && last_cmd == 16'h1000, "R5 open and close commands",
                    {first_cmd, last_cmd}, 32'h30001000);
                chk(viol == 0, "R6 data loaded before every write command", viol, 0);
            end else begin
                for (int i = 0; i < NW; i++)
                    if (bufm[i] != pat(sd, i)) same = 0;
                chk(same, "R2 R4 buffer equals memory incl. slot and control words", 0, 0);
                chk(ncmd == 64 && viol == 0, "R2 pull command count", ncmd, 64);
                chk(last_cmd == 16'h803F, "R2 last read command", last_cmd, 16'h803F);
            end
        end

        // R9: pull whose first command never completes
        lat = 13;
        do_fill(16'h0101, 16'h0202);
        run_op(1'b0, cyc, t_o, cs, bok);
        chk(t_o == 1'b1, "R9 pull timeout flagged", t_o, 1);
        chk(cyc == TO_CYC, "R9 R8 timeout cycle", cyc, TO_CYC);
        chk(ncmd == 1 && cs == 0, "R9 no further command after timeout", ncmd, 1);

        // R9: push whose open command never completes
        do_fill(16'h0303, 16'h0404);
        run_op(1'b1, cyc, t_o, cs, bok);
        chk(t_o == 1'b1 && ncmd == 1 && first_cmd == 16'h3000, "R9 push timeout on open",
            ncmd, 1);

        // recovery after a timeout
        lat = 1;
        do_fill(16'h0505, 16'h0606);
        run_op(1'b0, cyc, t_o, cs, bok);
        chk(t_o == 1'b0 && cs == cfg_sum(16'h0505), "R10 timeout cleared by next start",
            cs, cfg_sum(16'h0505));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule